// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block brings an SDRAM device out of reset and keeps its contents alive. After the chip reset it waits out a stabilization period measured in core clocks, with the clock enable held low for the first half and raised for the second half. It then issues a precharge of every bank, one auto-refresh and a mode-register load. Each of these commands is separated from the next by its own parameterized delay. The block then settles into an idle state, and from there it starts an auto-refresh each time an interval counter runs out.

The block also paces a host processor. The host raises a one-cycle request strobe together with an address and a write select. When the sequencer is idle with no refresh due, the host sees READY on the very next cycle. A request that arrives during power-up or during a refresh is held. It is answered once the sequence or the refresh recovery time is over. READY is never given while the memory is being initialized or refreshed. The data path of reads and writes is outside this block.

Top module: `sdram_init_refresh`

## Requirements
- R1: While reset is low and during the first half of the stabilization period, the clock enable is low, the chip select is high (command inhibit: cs_n=1) and READY is low. READY stays low for the whole initialization.
- R2: The stabilization period lasts STABLE_US*CLK_MHZ clocks. The clock enable rises halfway through, stays high from then on, and NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1) is driven until the period ends.
- R3: On the first cycle after stabilization the block drives a precharge-all command (0,0,1,0). The address carries only bit 10 set and the bank is 0.
- R4: The initialization auto-refresh (0,0,0,1) follows the precharge by exactly T_RP clocks, with NOP in between.
- R5: The mode-register load (0,0,0,0) follows that refresh by exactly T_RFC clocks, with NOP in between. Its address is CAS_LAT in bits 6:4 and BURST_CODE in bits 2:0, every other bit is 0, and the bank is 0.
- R6: The idle state begins T_MRD clocks after the mode-register load. Outside refresh commands, only NOP is driven from then on.
- R7: Counting from the first idle cycle t0, the k-th periodic auto-refresh is issued at t0+k*REF_INTERVAL+1. It slips to +2 when a host cycle occupies that slot.
- R8: For T_RFC clocks after each auto-refresh, only NOP is driven and READY stays low.
- R9: A request presented while the block is idle with no refresh due raises READY on the next cycle, for one cycle only.
- R10: A request presented during a refresh, or in the idle cycle just before one starts, raises READY T_RFC+1 clocks after that refresh command.
- R11: A request presented during initialization raises READY one clock after the first idle cycle.
- R12: While READY is high, the transfer address and write select outputs equal the values presented with the request being answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | core clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| host_req_i | input | 1 | host request strobe, one cycle |
| host_addr_i | input | HADDR_W | host address for the request |
| host_we_i | input | 1 | host write select (1 = write) |
| host_ready_o | output | 1 | READY to the host |
| xfer_addr_o | output | HADDR_W | address of the request being answered |
| xfer_we_o | output | 1 | write select of the request being answered |
| sd_cke_o | output | 1 | SDRAM clock enable |
| sd_cs_n_o | output | 1 | SDRAM chip select, active low |
| sd_ras_n_o | output | 1 | SDRAM row strobe, active low |
| sd_cas_n_o | output | 1 | SDRAM column strobe, active low |
| sd_we_n_o | output | 1 | SDRAM write enable, active low |
| sd_ba_o | output | BA_W | SDRAM bank select |
| sd_a_o | output | A_W | SDRAM address lines |

## Verification
Every result has a fixed place in time. The command outputs follow the state register with no further stage, so each initialization command appears a whole number of T_RP, T_RFC or T_MRD clocks after the clock-enable edge. A refresh appears one clock after its interval expires. READY comes one clock after an idle request, T_RFC+1 clocks after the refresh command for a held request, and one clock after the first idle cycle for a request made during power-up. The bench counts clock edges, samples every output on the falling edge, and compares each output against the cycle predicted from these offsets. It anchors on the clock-enable rise and on each observed refresh command.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS  = 4'b0000,
    CMD_AREF = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_NOP  = 4'b0111,
    CMD_INH  = 4'b1111
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_STABLE,
    ST_PRE,
    ST_PRE_W,
    ST_INIT_REF,
    ST_INIT_REF_W,
    ST_MRS,
    ST_MRS_W,
    ST_IDLE,
    ST_REF,
    ST_REF_W,
    ST_HOST
  } seq_state_e;

endpackage

// File: rtl/sdram_seq_rst_sync.sv
module sdram_seq_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/sdram_seq_ref_timer.sv
module sdram_seq_ref_timer #(
  parameter int unsigned INTERVAL = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic start_i,
  output logic pend_o
);

  localparam int unsigned CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          wrap;

  always_comb begin
    wrap   = (cnt_q == LAST);
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (!run_i) begin
      cnt_d  = '0;
      pend_d = 1'b0;
    end else begin
      if (start_i) pend_d = 1'b0;
      if (wrap) begin
        cnt_d  = '0;
        pend_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  assert_pend_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !pend_o);

  assert_no_pend_init_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !pend_o);

endmodule

// File: rtl/sdram_seq_host_hold.sv
module sdram_seq_host_hold #(
  parameter int unsigned AW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic          clr_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic          we_o
);

  logic          valid_q, valid_d;
  logic [AW-1:0] addr_q;
  logic          we_q;
  logic          cap;

  always_comb begin
    cap     = req_i && !valid_q;
    valid_d = valid_q;
    if (clr_i)    valid_d = 1'b0;
    else if (cap) valid_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      we_q   <= 1'b0;
    end else if (cap) begin
      addr_q <= addr_i;
      we_q   <= we_i;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign we_o    = we_q;

  assert_hold_stable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !clr_i) |=> (valid_o && $stable(addr_o) && $stable(we_o)));

endmodule

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
  import sdram_seq_pkg::*;
#(
  parameter int unsigned STABLE_CYC = 10000,
  parameter int unsigned T_RP       = 3,
  parameter int unsigned T_RFC      = 7,
  parameter int unsigned T_MRD      = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    host_any_i,
  input  logic    ref_pend_i,
  output sd_cmd_e cmd_o,
  output logic    cke_o,
  output logic    sel_pre_o,
  output logic    sel_mode_o,
  output logic    ready_o,
  output logic    op_o,
  output logic    ref_start_o,
  output logic    serve_o
);

  localparam int unsigned HALF  = STABLE_CYC / 2;
  localparam int unsigned DMAX0 = (STABLE_CYC > T_RP) ? STABLE_CYC : T_RP;
  localparam int unsigned DMAX1 = (DMAX0 > T_RFC) ? DMAX0 : T_RFC;
  localparam int unsigned DMAX  = (DMAX1 > T_MRD) ? DMAX1 : T_MRD;
  localparam int unsigned CW    = $clog2(DMAX + 1);

  localparam logic [CW-1:0] STABLE_LAST = CW'(STABLE_CYC - 1);
  localparam logic [CW-1:0] CKE_AT      = CW'(HALF);
  localparam logic [CW-1:0] RP_LOAD     = CW'(T_RP - 2);
  localparam logic [CW-1:0] RFC_LOAD    = CW'(T_RFC - 2);
  localparam logic [CW-1:0] MRD_LOAD    = CW'(T_MRD - 2);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_STABLE: begin
        if (cnt_q == STABLE_LAST) begin
          state_d = ST_PRE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PRE: begin
        state_d = ST_PRE_W;
        cnt_d   = RP_LOAD;
      end
      ST_PRE_W: begin
        if (cnt_zero) state_d = ST_INIT_REF;
        else          cnt_d   = cnt_q - 1'b1;
      end
      ST_INIT_REF: begin
        state_d = ST_INIT_REF_W;
        cnt_d   = RFC_LOAD;
      end
      ST_INIT_REF_W: begin
        if (cnt_zero) state_d = ST_MRS;
        else          cnt_d   = cnt_q - 1'b1;
      end
      ST_MRS: begin
        state_d = ST_MRS_W;
        cnt_d   = MRD_LOAD;
      end
      ST_MRS_W: begin
        if (cnt_zero) state_d = ST_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      ST_IDLE: begin
        if (ref_pend_i)      state_d = ST_REF;
        else if (host_any_i) state_d = ST_HOST;
      end
      ST_REF: begin
        state_d = ST_REF_W;
        cnt_d   = RFC_LOAD;
      end
      ST_REF_W: begin
        if (cnt_zero) state_d = ST_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      ST_HOST: state_d = ST_IDLE;
      default: state_d = ST_STABLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_STABLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    cke_o = (state_q != ST_STABLE) || (cnt_q >= CKE_AT);
    unique case (state_q)
      ST_STABLE:            cmd_o = cke_o ? CMD_NOP : CMD_INH;
      ST_PRE:               cmd_o = CMD_PRE;
      ST_INIT_REF, ST_REF:  cmd_o = CMD_AREF;
      ST_MRS:               cmd_o = CMD_MRS;
      default:              cmd_o = CMD_NOP;
    endcase
  end

  assign sel_pre_o   = (state_q == ST_PRE);
  assign sel_mode_o  = (state_q == ST_MRS);
  assign ready_o     = (state_q == ST_HOST);
  assign serve_o     = (state_q == ST_HOST);
  assign ref_start_o = (state_q == ST_REF);
  assign op_o        = (state_q == ST_IDLE) || (state_q == ST_REF) ||
                       (state_q == ST_REF_W) || (state_q == ST_HOST);

  assert_cke_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);

  assert_no_ready_init_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_o |-> !ready_o);

  assert_ready_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  assert_ready_from_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(state_q == ST_IDLE));

  assert_ref_after_pend_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && ref_pend_i) |=> (cmd_o == CMD_AREF));

  assert_wait_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PRE_W && state_d != ST_PRE_W) |-> cnt_zero);

endmodule

// File: rtl/sdram_init_refresh.sv
module sdram_init_refresh
  import sdram_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ      = 100,
  parameter int unsigned STABLE_US    = 100,
  parameter int unsigned T_RP         = 3,
  parameter int unsigned T_RFC        = 7,
  parameter int unsigned T_MRD        = 2,
  parameter int unsigned REF_INTERVAL = 780,
  parameter int unsigned BURST_CODE   = 3,
  parameter int unsigned CAS_LAT      = 3,
  parameter int unsigned A_W          = 13,
  parameter int unsigned BA_W         = 2,
  parameter int unsigned HADDR_W      = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_req_i,
  input  logic [HADDR_W-1:0] host_addr_i,
  input  logic               host_we_i,
  output logic               host_ready_o,
  output logic [HADDR_W-1:0] xfer_addr_o,
  output logic               xfer_we_o,
  output logic               sd_cke_o,
  output logic               sd_cs_n_o,
  output logic               sd_ras_n_o,
  output logic               sd_cas_n_o,
  output logic               sd_we_n_o,
  output logic [BA_W-1:0]    sd_ba_o,
  output logic [A_W-1:0]     sd_a_o
);

  localparam int unsigned STABLE_CYC = CLK_MHZ * STABLE_US;
  localparam logic [A_W-1:0] PRE_WORD  = A_W'(1 << 10);
  localparam logic [A_W-1:0] MODE_WORD = A_W'(((CAS_LAT & 7) << 4) | (BURST_CODE & 7));

  logic    rst_sync;
  logic    hold_valid;
  logic    ref_pend;
  logic    sel_pre, sel_mode;
  logic    op_mode, ref_start, serve;
  sd_cmd_e cmd;

  sdram_seq_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync)
  );

  sdram_seq_host_hold #(.AW(HADDR_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync),
    .req_i   (host_req_i),
    .addr_i  (host_addr_i),
    .we_i    (host_we_i),
    .clr_i   (serve),
    .valid_o (hold_valid),
    .addr_o  (xfer_addr_o),
    .we_o    (xfer_we_o)
  );

  sdram_seq_ref_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync),
    .run_i   (op_mode),
    .start_i (ref_start),
    .pend_o  (ref_pend)
  );

  sdram_seq_fsm #(
    .STABLE_CYC (STABLE_CYC),
    .T_RP       (T_RP),
    .T_RFC      (T_RFC),
    .T_MRD      (T_MRD)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync),
    .host_any_i  (host_req_i || hold_valid),
    .ref_pend_i  (ref_pend),
    .cmd_o       (cmd),
    .cke_o       (sd_cke_o),
    .sel_pre_o   (sel_pre),
    .sel_mode_o  (sel_mode),
    .ready_o     (host_ready_o),
    .op_o        (op_mode),
    .ref_start_o (ref_start),
    .serve_o     (serve)
  );

  assign {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o} = cmd;
  assign sd_ba_o = '0;

  always_comb begin
    if (sel_pre)       sd_a_o = PRE_WORD;
    else if (sel_mode) sd_a_o = MODE_WORD;
    else               sd_a_o = '0;
  end

  assert_pre_a10_R3: assert property (@(posedge clk_i) disable iff (!rst_sync)
    (cmd == CMD_PRE) |-> (sd_a_o == PRE_WORD));

  assert_ref_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_sync)
    (cmd == CMD_AREF) |=> (cmd == CMD_NOP && !host_ready_o));

  assert_ready_nop_R8: assert property (@(posedge clk_i) disable iff (!rst_sync)
    host_ready_o |-> (cmd == CMD_NOP));

  assert_ready_held_R12: assert property (@(posedge clk_i) disable iff (!rst_sync)
    host_ready_o |-> $past(hold_valid || host_req_i));

endmodule

// File: tb/sdram_init_refresh_test.sv
module sdram_init_refresh_test;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ = 1, STABLE_US = 40, T_RP = 3, T_RFC = 6, T_MRD = 2, REF = 50;
  localparam int S = CLK_MHZ * STABLE_US, HALF = S / 2;
  localparam int END_CYC = 3400;
  localparam bit [3:0] C_MRS = 4'b0000, C_AREF = 4'b0001, C_PRE = 4'b0010,
                       C_NOP = 4'b0111, C_INH = 4'b1111;
  localparam bit [12:0] MODE_EXP = 13'h033;

  logic clk = 1'b0;
  logic rst_n;
  logic req;
  logic [23:0] addr;
  logic we;
  logic ready, xwe, cke, cs_n, ras_n, cas_n, we_n;
  logic [23:0] xaddr;
  logic [1:0] ba;
  logic [12:0] a;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_init_refresh #(
    .CLK_MHZ(CLK_MHZ), .STABLE_US(STABLE_US), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .REF_INTERVAL(REF), .BURST_CODE(3), .CAS_LAT(3)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .host_req_i(req), .host_addr_i(addr),
    .host_we_i(we), .host_ready_o(ready), .xfer_addr_o(xaddr), .xfer_we_o(xwe),
    .sd_cke_o(cke), .sd_cs_n_o(cs_n), .sd_ras_n_o(ras_n), .sd_cas_n_o(cas_n),
    .sd_we_n_o(we_n), .sd_ba_o(ba), .sd_a_o(a)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at %0t",
               rq, act, act, exp, exp, $time);
    end
  endtask

  function automatic bit [3:0] init_cmd(input int c, input int rs, input int pc,
                                        input int ac, input int mc);
    if (c < rs) return C_INH;
    if (c == pc) return C_PRE;
    if (c == ac) return C_AREF;
    if (c == mc) return C_MRS;
    return C_NOP;
  endfunction

  function automatic string init_tag(input int c, input int pc, input int ac, input int mc);
    if (c < pc) return "R2";
    if (c <= ac) return "R4";
    if (c <= mc) return "R5";
    return "R6";
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int cyc, rise, pre_c, aref_c, mrs_c, t0, inh_cnt;
    int last_aref, first_aref, n_aref, last_ready;
    bit out_v, out_we, prev_ready;
    int out_c;
    bit [23:0] out_addr;
    bit [3:0] cmd;
    rise = -1; t0 = -1; pre_c = -1; aref_c = -1; mrs_c = -1; inh_cnt = 0;
    last_aref = -1000; first_aref = -1; n_aref = 0; last_ready = -1;
    out_v = 0; out_we = 0; out_c = 0; out_addr = '0; prev_ready = 0;
    void'($urandom(32'd4242));
    rst_n = 1'b0; req = 1'b0; addr = '0; we = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(cke == 1'b0 && cs_n == 1'b1 && ready == 1'b0, "R1 reset", {cke, cs_n, ready}, 3'b010);
    end
    rst_n = 1'b1;
    cyc = 0;
    while (cyc < END_CYC) begin
      @(negedge clk);
      cyc++;
      req = 1'b0;
      cmd = {cs_n, ras_n, cas_n, we_n};

      // power-up sequence
      if (rise < 0) begin
        if (cke) begin
          rise = cyc;
          chk(inh_cnt >= HALF && inh_cnt <= HALF + 3, "R2 inhibit length", inh_cnt, HALF);
          pre_c = rise + (S - HALF); aref_c = pre_c + T_RP;
          mrs_c = aref_c + T_RFC; t0 = mrs_c + T_MRD;
        end else begin
          inh_cnt++;
          chk(cmd == C_INH && !ready, "R1 inhibit", {cmd, ready}, {C_INH, 1'b0});
        end
      end
      if (rise >= 0 && cyc < t0) begin
        chk(cmd == init_cmd(cyc, rise, pre_c, aref_c, mrs_c), init_tag(cyc, pre_c, aref_c, mrs_c),
            cmd, init_cmd(cyc, rise, pre_c, aref_c, mrs_c));
        chk(cke && !ready, "R1 ready low in init", {cke, ready}, 2'b10);
        if (cyc == pre_c) chk(a == 13'h400 && ba == 0, "R3 precharge address", a, 13'h400);
        if (cyc == mrs_c) chk(a == MODE_EXP && ba == 0, "R5 mode address", a, MODE_EXP);
      end

      // operating phase
      if (t0 >= 0 && cyc >= t0) begin
        if (cmd == C_AREF) begin
          n_aref++;
          if (first_aref < 0) first_aref = cyc;
          chk((cyc - t0 - n_aref * REF) inside {1, 2}, "R7 refresh slot",
              cyc - t0 - n_aref * REF, 1);
          last_aref = cyc;
        end else begin
          chk(cmd == C_NOP, (cyc - last_aref < T_RFC) ? "R8 nop after refresh" : "R6 idle nop",
              cmd, C_NOP);
        end
        if (cyc - last_aref <= T_RFC)
          chk(!ready, "R8 ready low in refresh", ready, 0);
        chk(cke, "R2 cke stays high", cke, 1);
      end

      // READY checking
      if (ready) begin
        chk(!prev_ready, "R9 single-cycle ready", prev_ready, 0);
        if (!out_v) chk(0, "R9 unsolicited ready", 1, 0);
        else begin
          int exp_c;
          string tg;
          if (last_aref >= out_c - T_RFC + 1 && last_aref <= out_c + 1) begin
            exp_c = last_aref + T_RFC + 1; tg = "R10 ready after refresh";
          end else if (t0 < 0 || out_c < t0) begin
            exp_c = t0 + 1; tg = "R11 ready after init";
          end else begin
            exp_c = out_c + 1; tg = "R9 ready next cycle";
          end
          chk(cyc == exp_c, tg, cyc, exp_c);
          chk(xaddr == out_addr && xwe == out_we, "R12 transfer fields",
              int'(xaddr), int'(out_addr));
          out_v = 0;
        end
        last_ready = cyc;
      end
      prev_ready = ready;
      if (out_v && t0 >= 0 && cyc > t0 && cyc - ((out_c > t0) ? out_c : t0) > T_RFC + 3) begin
        chk(0, "R10 request never answered", cyc - out_c, T_RFC + 1);
        out_v = 0;
      end

      // stimulus for the current cycle
      if (!out_v && cyc > last_ready) begin
        bit go;
        go = 0;
        if (cyc == 10) begin
          go = 1; addr = 24'hABCDE; we = 1'b1;
        end else if (first_aref > 0 && cyc == first_aref + 2) begin
          go = 1; addr = 24'h123456; we = 1'b0;
        end else if (first_aref > 0 && cyc == first_aref + T_RFC + 4) begin
          go = 1; addr = 24'h00F00D; we = 1'b1;
        end else if (first_aref > 0 && cyc > first_aref + T_RFC + 8 &&
                     $urandom_range(0, 4) == 0) begin
          go = 1; addr = 24'($urandom); we = 1'($urandom_range(0, 1));
        end
        if (go) begin
          req = 1'b1; out_v = 1; out_c = cyc; out_addr = addr; out_we = we;
        end
      end
    end
    chk(n_aref >= (END_CYC - t0) / REF - 1, "R7 refresh count", n_aref, (END_CYC - t0) / REF);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule